// File: doc/BRIEF.md
# Accelerometer SPI Command Frame Engine

This block is an SPI master that drives a high-g accelerometer using fixed 32-bit command frames. Each frame holds an opcode, a sensor-enable flag, a register address, a data byte, an odd/even check bit and an 8-bit CRC. The engine builds the frame and shifts it out MSB-first under an active-low chip select. It also captures the 32-bit word that the sensor returns during the same frame.

The sensor answers one frame late. A register read or a channel measurement is therefore two frames: a command frame, a wait of a set number of cycles, and then a fetch frame whose reply carries the answer. After reset the engine waits a startup delay. It then writes 0x01 to sensor register 0, which releases the sensor from its initialization phase. Only after that write does it accept requests.

Requests arrive on a valid/ready handshake. Results come back on a 16-bit bus with a one-cycle done strobe.

Top module: `sfe_engine`

## Requirements
- R1: A command frame places the opcode in bits 31:30, the sensor-enable flag in bit 29, the check bit in bit 28, the 5-bit address in bits 25:21 and the data byte in bits 20:13. Bits 27:26 and 12:8 are zero, and the CRC occupies bits 7:0.
- R2: The CRC is computed over bits 23:0 of the frame before the CRC and the check bit are inserted, so the low byte is zero at that point. It runs MSB-first from a zero start, with polynomial 0x97, no reflection and no final inversion. The check bit (bit 28) is the XOR of those same 24 bits.
- R3: A request of kind 0 (write), or of the unused kind code 3, sends one frame with opcode 01 carrying the requested address and data. The reply to that frame is discarded, and done is raised with result 0.
- R4: A request of kind 1 (read) sends opcode 11 with the address and data 0. After the gap it sends the fetch frame 0xC0000000. The result is bits 20:13 of the reply to the fetch frame, zero-extended to 16 bits.
- R5: A request of kind 2 (measure) sends a frame whose bits 31:30 hold the 2-bit channel, with bit 29 set and the address and data at 0. After the gap it sends the fetch frame 0xC0000000. The result is reply bits 25:12, read as a 14-bit two's-complement value and sign-extended to 16 bits.
- R6: Each frame is 32 SCK rising edges in SPI mode 0. SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising edge. The SCK period is CLK_DIV system clocks, and chip select stays low for the whole frame.
- R7: Between any two frames, chip select stays high for at least CLK_DIV cycles. Between the command frame and the fetch frame of a read or measure, it stays high for at least GAP_CYCLES cycles.
- R8: After reset, the first frame starts no earlier than STARTUP_CYCLES cycles later. That frame is a register write of 0x01 to address 0, and req_ready stays low until this write has completed.
- R9: req_ready is high only while the engine is idle, and a request is taken on a cycle where both req_valid and req_ready are high. done is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_kind | input | 2 | 0 write, 1 read, 2 measure |
| req_addr | input | 5 | Register address |
| req_data | input | 8 | Write data |
| req_chan | input | 2 | Measurement channel |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Register byte (zero-extended) or sign-extended measurement |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The hardest condition to reach from the ports is the one-frame-late pairing of replies. A wrong design can return the reply to the command frame instead of the reply to the fetch frame and still look plausible. The bench's sensor model prepares each reply from the frame it received just before, so the correct answer appears only in the fetch frame. It fills every bit outside the result field with ones, which exposes any mistake in field extraction. Measurements are driven at the 14-bit extremes (0x1FFF, 0x2000 and 0x3FFF) to reach the sign-extension boundary.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [1:0] {
        KIND_WRITE = 2'd0,
        KIND_READ  = 2'd1,
        KIND_MEAS  = 2'd2,
        KIND_SPARE = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        logic [4:0]  addr;
        logic [7:0]  data;
        logic [1:0]  chan;
    } req_t;

    localparam int          FRAME_W   = 32;
    localparam logic [7:0]  CRC_POLY  = 8'h97;
    localparam logic [1:0]  OP_WRITE  = 2'b01;
    localparam logic [1:0]  OP_FETCH  = 2'b11;
    localparam logic [31:0] FETCH_RAW = 32'hC000_0000;

    // Unsealed command word: check bit and CRC byte left at zero.
    function automatic logic [31:0] raw_cmd(input logic [1:0] op, input logic sen,
                                            input logic [4:0] addr, input logic [7:0] data);
        return {op, sen, 1'b0, 2'b00, addr, data, 13'd0};
    endfunction

    // Bitwise MSB-first CRC over the 24 low bits.
    function automatic logic [7:0] crc_24(input logic [23:0] bits);
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = 23; i >= 0; i--) begin
            fb = c[7] ^ bits[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    function automatic logic [31:0] seal(input logic [31:0] raw);
        logic [31:0] w;
        w       = raw;
        w[28]   = ^raw[23:0];
        w[7:0]  = crc_24(raw[23:0]);
        return w;
    endfunction

endpackage

// File: rtl/sfe_spi_shift.sv
module sfe_spi_shift #(
    parameter int CLK_DIV = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] tx_word,
    input  logic        miso,
    output logic        busy,
    output logic        done,
    output logic [31:0] rx_word,
    output logic        sck,
    output logic        mosi,
    output logic        cs_n
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int DIV_W = $clog2(CLK_DIV);

    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_TAIL, SH_GUARD} sh_st_e;

    sh_st_e           st;
    logic [DIV_W-1:0] div;
    logic [4:0]       bit_idx;
    logic [31:0]      sreg;

    assign busy = (st != SH_IDLE);
    assign mosi = sreg[31];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SH_IDLE;
            div     <= '0;
            bit_idx <= '0;
            sreg    <= '0;
            rx_word <= '0;
            sck     <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SH_IDLE: if (start) begin
                    sreg    <= tx_word;
                    cs_n    <= 1'b0;
                    div     <= '0;
                    bit_idx <= '0;
                    st      <= SH_SHIFT;
                end
                SH_SHIFT: if (div == DIV_W'(HALF - 1)) begin
                    div <= '0;
                    sck <= ~sck;
                    if (!sck) begin
                        rx_word <= {rx_word[30:0], miso};
                    end else if (bit_idx == 5'd31) begin
                        st <= SH_TAIL;
                    end else begin
                        sreg    <= {sreg[30:0], 1'b0};
                        bit_idx <= bit_idx + 5'd1;
                    end
                end else begin
                    div <= div + 1'b1;
                end
                SH_TAIL: if (div == DIV_W'(HALF - 1)) begin
                    div  <= '0;
                    cs_n <= 1'b1;
                    st   <= SH_GUARD;
                end else begin
                    div <= div + 1'b1;
                end
                default: if (div == DIV_W'(CLK_DIV - 1)) begin
                    div  <= '0;
                    done <= 1'b1;
                    st   <= SH_IDLE;
                end else begin
                    div <= div + 1'b1;
                end
            endcase
        end
    end

    // R6: no clock activity and no selection while idle
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (st == SH_IDLE) |-> (cs_n && !sck));
    // R6: SCK rests low whenever the sensor is deselected
    assert_sck_low_deselected_R6: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);
    // R6: a frame ends only after all 32 bits
    assert_full_frame_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (bit_idx == 5'd31));

endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
    import sfe_pkg::*;
#(
    parameter int STARTUP_CYCLES = 10000,
    parameter int GAP_CYCLES     = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  req_t        req,
    output logic        req_ready,
    output logic        done,
    output logic [15:0] result,
    output logic        xfer_start,
    output logic [31:0] xfer_word,
    input  logic        xfer_busy,
    input  logic        xfer_done,
    input  logic [31:0] xfer_rx
);
    localparam int CNT_MAX = (STARTUP_CYCLES > GAP_CYCLES) ? STARTUP_CYCLES : GAP_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef enum logic [2:0] {
        P_BOOT, P_INIT_WAIT, P_IDLE, P_CMD_WAIT, P_GAP, P_FETCH_WAIT
    } ph_e;

    ph_e              ph;
    req_t             cur;
    logic [CNT_W-1:0] cnt;
    logic             init_seen;
    logic             two_frame;

    assign req_ready = (ph == P_IDLE);
    assign two_frame = (cur.kind == KIND_READ) || (cur.kind == KIND_MEAS);

    function automatic logic [31:0] cmd_for(input req_t r);
        case (r.kind)
            KIND_MEAS: return seal(raw_cmd(r.chan, 1'b1, 5'd0, 8'd0));
            KIND_READ: return seal(raw_cmd(OP_FETCH, 1'b0, r.addr, 8'd0));
            default:   return seal(raw_cmd(OP_WRITE, 1'b0, r.addr, r.data));
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= P_BOOT;
            cur        <= '0;
            cnt        <= '0;
            init_seen  <= 1'b0;
            done       <= 1'b0;
            result     <= '0;
            xfer_start <= 1'b0;
            xfer_word  <= '0;
        end else begin
            done       <= 1'b0;
            xfer_start <= 1'b0;
            case (ph)
                P_BOOT: if (cnt == CNT_W'(STARTUP_CYCLES - 1)) begin
                    cnt        <= '0;
                    xfer_start <= 1'b1;
                    xfer_word  <= seal(raw_cmd(OP_WRITE, 1'b0, 5'd0, 8'h01));
                    ph         <= P_INIT_WAIT;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                P_INIT_WAIT: if (xfer_done) begin
                    init_seen <= 1'b1;
                    ph        <= P_IDLE;
                end
                P_IDLE: if (req_valid) begin
                    cur        <= req;
                    xfer_start <= 1'b1;
                    xfer_word  <= cmd_for(req);
                    ph         <= P_CMD_WAIT;
                end
                P_CMD_WAIT: if (xfer_done) begin
                    if (two_frame) begin
                        cnt <= '0;
                        ph  <= P_GAP;
                    end else begin
                        done   <= 1'b1;
                        result <= '0;
                        ph     <= P_IDLE;
                    end
                end
                P_GAP: if (cnt == CNT_W'(GAP_CYCLES - 1)) begin
                    cnt        <= '0;
                    xfer_start <= 1'b1;
                    xfer_word  <= seal(FETCH_RAW);
                    ph         <= P_FETCH_WAIT;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: if (xfer_done) begin
                    done <= 1'b1;
                    if (cur.kind == KIND_READ)
                        result <= {8'h00, xfer_rx[20:13]};
                    else
                        result <= {{2{xfer_rx[25]}}, xfer_rx[25:12]};
                    ph <= P_IDLE;
                end
            endcase
        end
    end

    // R9: never offer to take a request while a frame is on the wire
    assert_ready_only_idle_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !xfer_busy);
    // R9: completion strobe lasts one cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: no request accepted before the init write finished
    assert_no_req_before_init_R8: assert property (@(posedge clk) disable iff (rst)
        !init_seen |-> !req_ready);
    // R4: second frame of a two-frame exchange is the fetch word
    assert_fetch_word_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer_start && ph == P_FETCH_WAIT) |-> (xfer_word == FETCH_RAW));
    // R5: measurement command carries channel and sensor-enable
    assert_meas_cmd_R5: assert property (@(posedge clk) disable iff (rst)
        (xfer_start && ph == P_CMD_WAIT && cur.kind == KIND_MEAS)
            |-> (xfer_word[29] && xfer_word[31:30] == cur.chan));

endmodule

// File: rtl/sfe_engine.sv
module sfe_engine
    import sfe_pkg::*;
#(
    parameter int CLK_DIV        = 128,
    parameter int STARTUP_CYCLES = 10000,
    parameter int GAP_CYCLES     = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [4:0]  req_addr,
    input  logic [7:0]  req_data,
    input  logic [1:0]  req_chan,
    output logic        done,
    output logic [15:0] result,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);
    req_t        req;
    logic        xfer_start;
    logic [31:0] xfer_word;
    logic        xfer_busy;
    logic        xfer_done;
    logic [31:0] xfer_rx;

    assign req = '{kind: kind_e'(req_kind), addr: req_addr, data: req_data, chan: req_chan};

    sfe_seq #(
        .STARTUP_CYCLES (STARTUP_CYCLES),
        .GAP_CYCLES     (GAP_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req        (req),
        .req_ready  (req_ready),
        .done       (done),
        .result     (result),
        .xfer_start (xfer_start),
        .xfer_word  (xfer_word),
        .xfer_busy  (xfer_busy),
        .xfer_done  (xfer_done),
        .xfer_rx    (xfer_rx)
    );

    sfe_spi_shift #(
        .CLK_DIV (CLK_DIV)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (xfer_start),
        .tx_word (xfer_word),
        .miso    (spi_miso),
        .busy    (xfer_busy),
        .done    (xfer_done),
        .rx_word (xfer_rx),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n)
    );

endmodule

// File: tb/sfe_engine_test.sv
module sfe_engine_test;
    localparam int CLK_DIV = 4;
    localparam int STARTUP = 20;
    localparam int GAP     = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [4:0]  req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [1:0]  req_chan = '0;
    logic        done;
    logic [15:0] result;
    logic        spi_sck, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sfe_engine #(.CLK_DIV(CLK_DIV), .STARTUP_CYCLES(STARTUP), .GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data), .req_chan(req_chan),
        .done(done), .result(result), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // ---------------- sensor model ----------------
    int          cyc = 0;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    logic [31:0] frames [0:7];
    int          frame_bits [0:7];
    int          frame_gap [0:7];
    int          frame_cnt = 0;
    logic [31:0] rx_sh = '0;
    int          bits = 0;
    int          idx_out = -1;
    logic [31:0] reply_cur = '0;
    logic [31:0] reply_next = 32'hFFFF_FFFF;
    int          cs_rise_t = -1;
    int          first_fall_t = -1;
    int          last_rise = -1;
    int          sck_bad = 0;
    int          min_cs_high = 1000000;
    logic [7:0]  reg_tab [0:31];
    logic [13:0] meas_tab [0:3];

    always @(negedge spi_cs_n) begin
        reply_cur = reply_next;
        spi_miso  = reply_cur[31];
        idx_out   = 30;
        rx_sh     = '0;
        bits      = 0;
        last_rise = -1;
        if (first_fall_t < 0) first_fall_t = cyc;
        if (frame_cnt < 8) frame_gap[frame_cnt] = (cs_rise_t < 0) ? -1 : cyc - cs_rise_t;
        if (cs_rise_t >= 0 && cyc - cs_rise_t < min_cs_high) min_cs_high = cyc - cs_rise_t;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        rx_sh = {rx_sh[30:0], spi_mosi};
        bits++;
        if (last_rise >= 0 && cyc - last_rise != CLK_DIV) sck_bad++;
        last_rise = cyc;
    end

    always @(negedge spi_sck) if (!spi_cs_n && idx_out >= 0) begin
        spi_miso = reply_cur[idx_out];
        idx_out--;
    end

    always @(posedge spi_cs_n) if (bits > 0) begin
        if (frame_cnt < 8) begin
            frames[frame_cnt]     = rx_sh;
            frame_bits[frame_cnt] = bits;
        end
        frame_cnt++;
        cs_rise_t = cyc;
        bits = 0;
        if (rx_sh[29])
            reply_next = {6'h3F, meas_tab[rx_sh[31:30]], 12'hFFF};
        else if (rx_sh[31:30] == 2'b11)
            reply_next = {11'h7FF, reg_tab[rx_sh[25:21]], 13'h1FFF};
        else
            reply_next = 32'hFFFF_FFFF;
    end

    // ---------------- expected-value helpers ----------------
    function automatic logic [31:0] exp_frame(input logic [1:0] op, input logic sen,
                                              input logic [4:0] addr, input logic [7:0] data);
        logic [31:0] w;
        logic [7:0]  b [0:2];
        int          acc;
        logic        par;
        w = (32'(op) << 30) | (32'(sen) << 29) | (32'(addr) << 21) | (32'(data) << 13);
        b[0] = w[23:16]; b[1] = w[15:8]; b[2] = w[7:0];
        acc = 0;
        par = 1'b0;
        for (int k = 0; k < 3; k++) begin
            acc = acc ^ int'(b[k]);
            for (int j = 0; j < 8; j++) begin
                acc = acc << 1;
                if ((acc & 32'h100) != 0) acc = acc ^ 32'h197;
                par = par ^ b[k][j];
            end
        end
        return w | (32'(par) << 28) | 32'(acc & 8'hFF);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] kind, input logic [4:0] addr,
                           input logic [7:0] data, input logic [1:0] chan,
                           output logic [15:0] res);
        int waited;
        waited = 0;
        while (!req_ready && waited < 10000) begin @(negedge clk); waited++; end
        frame_cnt = 0;
        req_kind = kind; req_addr = addr; req_data = data; req_chan = chan;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 ready low while busy", 32'(req_ready), 32'd0);
        waited = 0;
        while (!done && waited < 10000) begin @(negedge clk); waited++; end
        res = result;
        @(negedge clk);
        check("R9 done lasts one cycle", 32'(done), 32'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_and_init();
        repeat (3) @(negedge clk);
        check("R8 cs idle in reset", 32'(spi_cs_n), 32'd1);
        check("R8 ready low in reset", 32'(req_ready), 32'd0);
        check("R9 done low in reset", 32'(done), 32'd0);
        rst = 1'b0;
        while (!req_ready) @(negedge clk);
        check("R8 one init frame", 32'(frame_cnt), 32'd1);
        check("R8 init frame write 0x01 to reg 0", frames[0], exp_frame(2'b01, 1'b0, 5'd0, 8'h01));
        check("R8 startup delay respected", 32'(first_fall_t >= STARTUP), 32'd1);
        check("R6 32 clocks per frame", 32'(frame_bits[0]), 32'd32);
    endtask

    task automatic t_write(input logic [4:0] addr, input logic [7:0] data, input logic [1:0] kind);
        logic [15:0] r;
        run_req(kind, addr, data, 2'd0, r);
        check("R3 write uses one frame", 32'(frame_cnt), 32'd1);
        check("R1 R2 R3 write frame", frames[0], exp_frame(2'b01, 1'b0, addr, data));
        check("R3 write result zero", 32'(r), 32'd0);
    endtask

    task automatic t_read(input logic [4:0] addr, input logic [7:0] val);
        logic [15:0] r;
        reg_tab[addr] = val;
        run_req(2'd1, addr, 8'h5A, 2'd0, r);
        check("R4 read uses two frames", 32'(frame_cnt), 32'd2);
        check("R1 R2 R4 read command frame", frames[0], exp_frame(2'b11, 1'b0, addr, 8'h00));
        check("R4 fetch frame", frames[1], 32'hC000_0000);
        check("R4 read result", 32'(r), 32'(val));
        check("R7 gap before fetch", 32'(frame_gap[1] >= GAP), 32'd1);
    endtask

    task automatic t_meas(input logic [1:0] ch, input logic [13:0] val);
        logic [15:0] r;
        meas_tab[ch] = val;
        run_req(2'd2, 5'd0, 8'h00, ch, r);
        check("R5 measure uses two frames", 32'(frame_cnt), 32'd2);
        check("R1 R2 R5 measure command frame", frames[0], exp_frame(ch, 1'b1, 5'd0, 8'h00));
        check("R5 fetch frame", frames[1], 32'hC000_0000);
        check("R5 measure result", 32'(r), 32'({{2{val[13]}}, val}));
        check("R7 gap before fetch", 32'(frame_gap[1] >= GAP), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) reg_tab[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 4; i++) meas_tab[i] = '0;
        t_reset_and_init();
        t_write(5'h1F, 8'hFF, 2'd0);
        t_write(5'h0A, 8'h3C, 2'd0);
        t_write(5'h05, 8'h81, 2'd3);
        t_read(5'h0C, 8'hA7);
        t_read(5'h00, 8'h00);
        t_meas(2'd0, 14'h1FFF);
        t_meas(2'd1, 14'h2000);
        t_meas(2'd2, 14'h3FFF);
        t_meas(2'd3, 14'h0123);
        check("R6 SCK period equals divider", 32'(sck_bad), 32'd0);
        check("R7 cs high at least one SCK period", 32'(min_cs_high >= CLK_DIV), 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule